// File: doc/BRIEF.md
# Serial Frame Lock Detector

This block sits on the receive side of a low-rate serial link. Its input is a bit stream framed by a modem clock that has no phase relation to the system clock. Each frame is a fixed run of code words, and each word has a known length. Word 0 of every frame carries a pitch value. In frames with no voicing, the transmitter puts a reserved all-ones value in that slot. That value is too high to be a real pitch, so the receiver can use it as a frame marker.

The block moves the modem clock and data into the system clock domain and takes one bit at each rising modem clock edge. While it is unlocked, it slides a window over the stream and records the bit position, within a frame-length cycle, at which the marker ends. It counts how many frames in a row show the marker at that same position. When that count reaches six, the block declares lock. It then loads its word and bit counters so that the next bit starts word 1. From that point it cuts the stream into words, using one of two length tables chosen by a rate input. It emits each word with its index and flags the last word of every frame.

Top module: `fsync_detector`

## Requirements
- R1: While reset is asserted, `locked`, `word_valid` and `frame_done` are 0.
- R2: A bit is taken only on a rising edge of `modem_clk`, using the value `modem_dat` has at that edge. Data that changes while `modem_clk` is high has no effect.
- R3: Lock is declared after the 6-bit marker 111111 has ended at the same bit position in six consecutive frames. It is not declared after five.
- R4: If a frame passes with no marker at the tracked position, the count restarts, and six more consecutive marker frames are needed.
- R5: A marker found at a different position, for example after a bit slip, becomes the new candidate with a count of one. Six consecutive frames at the new position are then needed.
- R6: The first word emitted after lock has index 1 and consists of the bits that directly follow the marker that completed the lock.
- R7: Words are received MSB first and output right-aligned in `word_data`, with `word_idx` giving the position in the frame. With `rate_sel`=0 the lengths of words 0..3 are 6,5,5,4. With `rate_sel`=1 they are 6,4,4,6.
- R8: `frame_done` is high exactly in the cycle that `word_valid` is high for word index 3, the last word of the frame.
- R9: No word is emitted before lock. Once declared, lock stays set until reset, even when later frames carry no marker.
- R10: After lock, a frame whose pitch slot holds the marker emits it as word 0 with value 63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| modem_clk | input | 1 | Bit clock from the modem, asynchronous |
| modem_dat | input | 1 | Serial data, valid at rising modem clock edges |
| rate_sel | input | 1 | Picks the word-length table (0 or 1) |
| word_valid | output | 1 | One-cycle strobe: a word is complete |
| word_data | output | 6 | Completed word, right-aligned |
| word_idx | output | 2 | Index of the word within its frame |
| frame_done | output | 1 | Strobe with the last word of a frame |
| locked | output | 1 | Frame alignment has been established |

## Verification
The hardest cases to reach from the ports are the two ways the running count can restart after it has partly built up: a frame whose marker slot is missing, and a slip that moves the marker to a new position. The stimulus builds frames bit by bit with a controlled modem clock. It chooses the data words so that no stray run of six ones can form anywhere. It then sends a few marker frames, breaks the sequence with a plain frame or with inserted bits, and sends exactly five and then six further marker frames. Data is toggled while the modem clock is high, so that sampling on the wrong edge shows up as corrupted words.

// File: rtl/fsync_pkg.sv
package fsync_pkg;
  localparam int unsigned LEN_FIELD_W = 4;

  // Length of word idx from a packed table, word 0 in the low nibble.
  function automatic logic [LEN_FIELD_W-1:0] len_field(input logic [63:0] tab,
                                                       input int unsigned idx);
    return tab[idx*LEN_FIELD_W +: LEN_FIELD_W];
  endfunction
endpackage

// File: rtl/fsync_cdc.sv
module fsync_cdc #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mclk_in,
  input  logic mdat_in,
  output logic bit_en,
  output logic bit_val
);
  logic [STAGES-1:0] clk_pipe;
  logic [STAGES-1:0] dat_pipe;
  logic              clk_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_pipe <= '0;
      dat_pipe <= '0;
      clk_last <= 1'b0;
    end else begin
      clk_pipe <= {clk_pipe[STAGES-2:0], mclk_in};
      dat_pipe <= {dat_pipe[STAGES-2:0], mdat_in};
      clk_last <= clk_pipe[STAGES-1];
    end
  end

  assign bit_en  = clk_pipe[STAGES-1] & ~clk_last;
  assign bit_val = dat_pipe[STAGES-1];
endmodule

// File: rtl/fsync_hunter.sv
module fsync_hunter #(
  parameter int                FRAME_BITS  = 20,
  parameter int                SYNC_W      = 6,
  parameter logic [SYNC_W-1:0] SYNC_VAL    = '1,
  parameter int                LOCK_FRAMES = 6,
  localparam int POS_W = $clog2(FRAME_BITS),
  localparam int CNT_W = $clog2(LOCK_FRAMES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             bit_val,
  input  logic             enable,
  output logic             lock_hit,
  output logic [CNT_W-1:0] run_cnt
);
  logic [SYNC_W-1:0] win_q, win_d;
  logic [POS_W-1:0]  pos_q, pos_d;
  logic [POS_W-1:0]  cand_q, cand_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [SYNC_W-1:0] win_shift;
  logic              match, at_cand, step;
  logic [CNT_W-1:0]  cnt_on_match;

  assign step         = bit_en & enable;
  assign win_shift    = {win_q[SYNC_W-2:0], bit_val};
  assign match        = (win_shift == SYNC_VAL);
  assign at_cand      = (cnt_q != '0) && (pos_q == cand_q);
  assign cnt_on_match = at_cand ? cnt_q + 1'b1 : CNT_W'(1);

  always_comb begin
    win_d  = win_q;
    pos_d  = pos_q;
    cand_d = cand_q;
    cnt_d  = cnt_q;
    if (step) begin
      win_d = win_shift;
      pos_d = (pos_q == POS_W'(FRAME_BITS - 1)) ? '0 : pos_q + 1'b1;
      if (match) begin
        cnt_d = cnt_on_match;
        if (!at_cand) cand_d = pos_q;
      end else if (at_cand) begin
        cnt_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q  <= '0;
      pos_q  <= '0;
      cand_q <= '0;
      cnt_q  <= '0;
    end else begin
      win_q  <= win_d;
      pos_q  <= pos_d;
      cand_q <= cand_d;
      cnt_q  <= cnt_d;
    end
  end

  assign lock_hit = step && match && (cnt_on_match == CNT_W'(LOCK_FRAMES));
  assign run_cnt  = cnt_q;
endmodule

// File: rtl/fsync_deframer.sv
module fsync_deframer #(
  parameter int                  NWORDS = 4,
  parameter int                  MAX_WL = 6,
  parameter logic [NWORDS*4-1:0] WL_A   = '0,
  parameter logic [NWORDS*4-1:0] WL_B   = '0,
  localparam int IDX_W = $clog2(NWORDS),
  localparam int BI_W  = $clog2(MAX_WL) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              bit_val,
  input  logic              lock_hit,
  input  logic              rate_sel,
  output logic              locked,
  output logic              word_valid,
  output logic [MAX_WL-1:0] word_data,
  output logic [IDX_W-1:0]  word_idx,
  output logic              frame_done
);
  import fsync_pkg::*;

  logic              lock_q, lock_d;
  logic [IDX_W-1:0]  wi_q, wi_d;
  logic [BI_W-1:0]   bi_q, bi_d;
  logic [MAX_WL-1:0] acc_q, acc_d, acc_shift;
  logic              vld_d, done_d;
  logic [MAX_WL-1:0] data_q, data_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              vld_q, done_q;
  logic [BI_W-1:0]   len_cur;

  assign len_cur   = BI_W'(rate_sel ? len_field(64'(WL_B), 32'(wi_q))
                                    : len_field(64'(WL_A), 32'(wi_q)));
  assign acc_shift = {acc_q[MAX_WL-2:0], bit_val};

  always_comb begin
    lock_d = lock_q;
    wi_d   = wi_q;
    bi_d   = bi_q;
    acc_d  = acc_q;
    vld_d  = 1'b0;
    done_d = 1'b0;
    data_d = data_q;
    idx_d  = idx_q;
    if (!lock_q) begin
      if (lock_hit) begin
        lock_d = 1'b1;
        wi_d   = IDX_W'(1);
        bi_d   = '0;
        acc_d  = '0;
      end
    end else if (bit_en) begin
      if (bi_q == len_cur - 1'b1) begin
        vld_d  = 1'b1;
        data_d = acc_shift;
        idx_d  = wi_q;
        done_d = (wi_q == IDX_W'(NWORDS - 1));
        wi_d   = (wi_q == IDX_W'(NWORDS - 1)) ? '0 : wi_q + 1'b1;
        bi_d   = '0;
        acc_d  = '0;
      end else begin
        bi_d  = bi_q + 1'b1;
        acc_d = acc_shift;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
      wi_q   <= '0;
      bi_q   <= '0;
      acc_q  <= '0;
      vld_q  <= 1'b0;
      done_q <= 1'b0;
      data_q <= '0;
      idx_q  <= '0;
    end else begin
      lock_q <= lock_d;
      wi_q   <= wi_d;
      bi_q   <= bi_d;
      acc_q  <= acc_d;
      vld_q  <= vld_d;
      done_q <= done_d;
      data_q <= data_d;
      idx_q  <= idx_d;
    end
  end

  assign locked     = lock_q;
  assign word_valid = vld_q;
  assign word_data  = data_q;
  assign word_idx   = idx_q;
  assign frame_done = done_q;
endmodule

// File: rtl/fsync_detector.sv
module fsync_detector #(
  parameter int                  FRAME_BITS  = 20,
  parameter int                  NWORDS      = 4,
  parameter int                  MAX_WL      = 6,
  parameter int                  SYNC_W      = 6,
  parameter logic [SYNC_W-1:0]   SYNC_VAL    = 6'h3F,
  parameter int                  LOCK_FRAMES = 6,
  parameter logic [NWORDS*4-1:0] WL_A        = {4'd4, 4'd5, 4'd5, 4'd6},
  parameter logic [NWORDS*4-1:0] WL_B        = {4'd6, 4'd4, 4'd4, 4'd6},
  localparam int IDX_W = $clog2(NWORDS),
  localparam int HC_W  = $clog2(LOCK_FRAMES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              modem_clk,
  input  logic              modem_dat,
  input  logic              rate_sel,
  output logic              word_valid,
  output logic [MAX_WL-1:0] word_data,
  output logic [IDX_W-1:0]  word_idx,
  output logic              frame_done,
  output logic              locked
);
  logic            bit_en;
  logic            bit_val;
  logic            lock_hit;
  logic [HC_W-1:0] hunt_cnt;

  fsync_cdc #(.STAGES(2)) u_cdc (
    .clk     (clk),
    .rst_n   (rst_n),
    .mclk_in (modem_clk),
    .mdat_in (modem_dat),
    .bit_en  (bit_en),
    .bit_val (bit_val)
  );

  fsync_hunter #(
    .FRAME_BITS  (FRAME_BITS),
    .SYNC_W      (SYNC_W),
    .SYNC_VAL    (SYNC_VAL),
    .LOCK_FRAMES (LOCK_FRAMES)
  ) u_hunt (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_en   (bit_en),
    .bit_val  (bit_val),
    .enable   (~locked),
    .lock_hit (lock_hit),
    .run_cnt  (hunt_cnt)
  );

  fsync_deframer #(
    .NWORDS (NWORDS),
    .MAX_WL (MAX_WL),
    .WL_A   (WL_A),
    .WL_B   (WL_B)
  ) u_defr (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_en     (bit_en),
    .bit_val    (bit_val),
    .lock_hit   (lock_hit),
    .rate_sel   (rate_sel),
    .locked     (locked),
    .word_valid (word_valid),
    .word_data  (word_data),
    .word_idx   (word_idx),
    .frame_done (frame_done)
  );
endmodule

module fsync_detector_chk #(
  parameter int NWORDS      = 4,
  parameter int LOCK_FRAMES = 6,
  parameter int IDX_W       = 2,
  parameter int HC_W        = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bit_en,
  input logic             locked,
  input logic             word_valid,
  input logic [IDX_W-1:0] word_idx,
  input logic             frame_done,
  input logic [HC_W-1:0]  hunt_cnt
);
  a_r9_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);

  a_r9_words_need_lock: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> locked);

  a_r8_done_on_last: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> (word_valid && word_idx == IDX_W'(NWORDS - 1)));

  a_r2_lock_on_bit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(bit_en));

  a_r2_word_on_bit: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> $past(bit_en));

  a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    hunt_cnt <= HC_W'(LOCK_FRAMES));
endmodule

bind fsync_detector fsync_detector_chk #(
  .NWORDS      (NWORDS),
  .LOCK_FRAMES (LOCK_FRAMES),
  .IDX_W       (IDX_W),
  .HC_W        (HC_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bit_en     (bit_en),
  .locked     (locked),
  .word_valid (word_valid),
  .word_idx   (word_idx),
  .frame_done (frame_done),
  .hunt_cnt   (hunt_cnt)
);

// File: tb/tb_fsync_detector.sv
`timescale 1ns/1ps
module tb_fsync_detector;
  logic       clk;
  logic       rst_n;
  logic       modem_clk;
  logic       modem_dat;
  logic       rate_sel;
  logic       word_valid;
  logic [5:0] word_data;
  logic [1:0] word_idx;
  logic       frame_done;
  logic       locked;

  int total = 0;
  int bad   = 0;
  logic [7:0] expq[$];

  fsync_detector dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .modem_clk  (modem_clk),
    .modem_dat  (modem_dat),
    .rate_sel   (rate_sel),
    .word_valid (word_valid),
    .word_data  (word_data),
    .word_idx   (word_idx),
    .frame_done (frame_done),
    .locked     (locked)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int len_of(input logic r, input int k);
    int ta[4] = '{6, 5, 5, 4};
    int tb[4] = '{6, 4, 4, 6};
    return r ? tb[k] : ta[k];
  endfunction

  // R2: data is toggled while modem_clk is high; only the rising-edge value counts
  task automatic send_bit(input logic b);
    @(negedge clk) modem_dat = b;
    repeat (8) @(negedge clk);
    modem_clk = 1'b1;
    repeat (4) @(negedge clk);
    modem_dat = ~b;
    repeat (4) @(negedge clk);
    modem_clk = 1'b0;
  endtask

  // mode 0: expect nothing, 1: expect words 1..3 (lock frame), 2: all words
  task automatic send_frame(input bit is_sync, input int mode, input int seed);
    logic [5:0] w[4];
    w[0] = is_sync ? 6'h3F : 6'((seed * 5 + 9) & 31);
    for (int k = 1; k < 4; k++) begin
      int ln = len_of(rate_sel, k);
      int mask = ((1 << (ln - 1)) - 1) & ~1;
      w[k] = 6'((seed * 13 + k * 11) & mask);
    end
    for (int k = 0; k < 4; k++) begin
      if (mode == 2 || (mode == 1 && k > 0)) expq.push_back({2'(k), w[k]});
    end
    for (int k = 0; k < 4; k++) begin
      int ln = len_of(rate_sel, k);
      for (int b = ln - 1; b >= 0; b--) send_bit(w[k][b]);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    modem_clk = 1'b0;
    modem_dat = 1'b0;
    rate_sel = 1'b0;
    expq.delete();
    repeat (3) @(negedge clk);
    chk(locked == 1'b0, "R1 locked", int'(locked), 0);
    chk(word_valid == 1'b0, "R1 word_valid", int'(word_valid), 0);
    chk(frame_done == 1'b0, "R1 frame_done", int'(frame_done), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && word_valid) begin
      if (expq.size() == 0) begin
        chk(1'b0, "R9 word before lock", int'(word_idx), -1);
      end else begin
        logic [7:0] e;
        e = expq.pop_front();
        chk(word_idx == e[7:6], "R7/R6 word_idx", int'(word_idx), int'(e[7:6]));
        chk(word_data == e[5:0], "R7/R10/R2 word_data", int'(word_data), int'(e[5:0]));
        chk(frame_done == (word_idx == 2'd3), "R8 frame_done", int'(frame_done),
            int'(word_idx == 2'd3));
      end
    end else if (rst_n && frame_done) begin
      chk(1'b0, "R8 frame_done without word", 1, 0);
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R3: five marker frames are not enough, the sixth locks
    do_reset();
    for (int i = 0; i < 5; i++) send_frame(1'b1, 0, i);
    chk(locked == 1'b0, "R3 after five", int'(locked), 0);
    send_frame(1'b1, 1, 5);
    chk(locked == 1'b1, "R3 after six", int'(locked), 1);
    send_frame(1'b0, 2, 10);
    send_frame(1'b1, 2, 11);   // R10 marker emitted as 63
    send_frame(1'b0, 2, 12);
    send_frame(1'b0, 2, 13);
    chk(locked == 1'b1, "R9 lock held", int'(locked), 1);
    chk(expq.size() == 0, "R6 all words seen", expq.size(), 0);

    // R4: a frame without marker restarts the count
    do_reset();
    for (int i = 0; i < 3; i++) send_frame(1'b1, 0, 20 + i);
    send_frame(1'b0, 0, 23);
    for (int i = 0; i < 5; i++) send_frame(1'b1, 0, 24 + i);
    chk(locked == 1'b0, "R4 five after gap", int'(locked), 0);
    send_frame(1'b1, 1, 29);
    chk(locked == 1'b1, "R4 six after gap", int'(locked), 1);
    rate_sel = 1'b1;           // R7 second length table
    send_frame(1'b0, 2, 30);
    send_frame(1'b1, 2, 31);
    chk(expq.size() == 0, "R7 rate table words", expq.size(), 0);

    // R5: a bit slip moves the marker, count restarts at the new offset
    do_reset();
    for (int i = 0; i < 4; i++) send_frame(1'b1, 0, 40 + i);
    for (int i = 0; i < 3; i++) send_bit(1'b0);
    for (int i = 0; i < 5; i++) send_frame(1'b1, 0, 44 + i);
    chk(locked == 1'b0, "R5 five after slip", int'(locked), 0);
    send_frame(1'b1, 1, 49);
    chk(locked == 1'b1, "R5 six after slip", int'(locked), 1);
    send_frame(1'b0, 2, 50);
    chk(expq.size() == 0, "R6 words after slip lock", expq.size(), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule